// File: doc/BRIEF.md
# Receive DMA Burst Request Engine

This block is the peripheral half of a slave DMA handshake. It moves received words from an internal buffer to host memory in bursts. Received words are pushed into a circular buffer. A small prefetch FIFO sits behind the buffer and holds the word that is presented on the read data bus. The block raises a request line whenever it has data to send. The host DMA controller answers with an acknowledge, and then with one read strobe per word. For each strobe the block raises ready once the word is on the bus.

Software programs three things through a small write port: an enable register, a burst-length code and a request-extend bit. The burst-length code sets how many transfers the host may make in one bus acquisition. The extend bit decides whether the request line falls on the final transfer of the burst or on the one before it. The host ends the whole job by pulsing an end-of-process input together with the final word. That pulse sets a sticky status flag, which can also raise an interrupt. Only a write of zero to the enable register clears the flag, and the engine must then be enabled again before it requests anything.

Top module: `rxdma_burst_ctrl`

## Requirements
- R1: The burst code is `reg_wdata[1:0]` of a control write (`reg_sel`=1). Codes 0, 1, 2 and 3 select a maximum of 1, 4, 8 and 12 transfers per acquisition.
- R2: `drq` is asserted only while the enable bit is high. The enable bit is `reg_wdata[1]` of an enable write (`reg_sel`=0). One clock after the enable bit goes low, `drq` is low.
- R3: When `rd_strobe` and `dmack` are both sampled high at a clock edge, `rdy` is high from the next clock. It stays high until the clock after `rd_strobe` is sampled low.
- R4: While `rdy` is high, `rd_data` carries the oldest unread word, in the order the words were pushed. Each completed transfer (the strobe falling while `rdy` is high) consumes exactly one word.
- R5: The extend bit is `reg_wdata[2]` of a control write. `drq` falls at the clock that starts transfer index L-1 of the burst when the bit is 0, and index L-2 when the bit is 1 (index 0 when L=1). Here L is the burst length and indices count from 0.
- R6: Two clocks after the host negates `dmack` following a burst, `drq` is asserted again, provided words remain and no end-of-process has been seen.
- R7: `drq` is not asserted while no word is held. It rises once a word arrives. `drq` also falls at the clock that starts a transfer taking the last held word, even when that comes before the burst limit.
- R8: `eop_in` sampled high while `dmack` is high during an open burst sets `eop_status`. This takes `drq` low on the next clock, and `drq` stays low for as long as `eop_status` is set.
- R9: `irq` is high exactly while `eop_status` and the interrupt-enable bit are both set. The interrupt-enable bit is `reg_wdata[3]` of a control write.
- R10: A write of 00h to the enable register clears `eop_status`, `irq`, the enable bit and the engine state. A non-zero enable write leaves `eop_status` set. Requests resume only after the 00h write and a later write with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_valid | input | 1 | Pushes `fill_data` into the receive buffer |
| fill_data | input | DATA_W | Received word to store |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the control register |
| reg_wdata | input | 8 | Register write data |
| dmack | input | 1 | DMA acknowledge from the host, active high |
| rd_strobe | input | 1 | Host read strobe, active high |
| eop_in | input | 1 | End-of-process from the host, active high |
| drq | output | 1 | DMA request |
| rdy | output | 1 | Data on the bus and transfer may complete |
| rd_data | output | DATA_W | Word presented during a transfer, zero otherwise |
| eop_status | output | 1 | Sticky end-of-process flag |
| irq | output | 1 | Interrupt |

## Verification
The hardest situations to reach are the end-of-process pulse that arrives with the final word and the re-enable sequence that follows it. The bench first runs a burst whose last strobe carries `eop_in`. It then pushes fresh data so that a request would otherwise be legal. Next it tries a non-zero enable write and checks that the request stays low, and only then issues the 00h write and a new enable. The early drop of `drq` when the data runs out before the burst limit is reached by loading just two words under the 12-transfer code.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } eng_state_e;

    localparam int BEAT_W = 4;

    typedef struct packed {
        eng_state_e          st;
        logic                drq;
        logic                rdy;
        logic [BEAT_W-1:0]   beat;
    } eng_t;

    typedef struct packed {
        logic       en;
        logic [1:0] code;
        logic       ext;
        logic       ie;
        logic       eop;
    } regs_t;

    function automatic logic [BEAT_W-1:0] burst_len(input logic [1:0] code);
        case (code)
            2'd0:    burst_len = 4'd1;
            2'd1:    burst_len = 4'd4;
            2'd2:    burst_len = 4'd8;
            default: burst_len = 4'd12;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] drop_index(input logic [1:0] code, input logic ext);
        logic [BEAT_W-1:0] len;
        len = burst_len(code);
        if (ext && (len > 4'd1)) drop_index = len - 4'd2;
        else                     drop_index = len - 4'd1;
    endfunction

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
    import rxdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic       sel_i,
    input  logic [7:0] wdata_i,
    input  logic       eop_hit_i,
    output logic       en_o,
    output logic [1:0] code_o,
    output logic       ext_o,
    output logic       eop_o,
    output logic       irq_o
);

    regs_t r_d, r_q;
    logic  clr_wr;

    assign clr_wr = we_i && !sel_i && (wdata_i == 8'h00);

    always_comb begin
        r_d = r_q;
        if (eop_hit_i) r_d.eop = 1'b1;
        if (we_i && !sel_i) begin
            r_d.en = wdata_i[1];
            if (wdata_i == 8'h00) r_d.eop = 1'b0;
        end
        if (we_i && sel_i) begin
            r_d.code = wdata_i[1:0];
            r_d.ext  = wdata_i[2];
            r_d.ie   = wdata_i[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o   = r_q.en;
    assign code_o = r_q.code;
    assign ext_o  = r_q.ext;
    assign eop_o  = r_q.eop;
    assign irq_o  = r_q.eop && r_q.ie;

    // R10: a zero write clears the status and the interrupt
    p_zero_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!eop_o && !irq_o && !en_o));

    // R8: status is sticky until a zero write
    p_eop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_o && !clr_wr) |=> eop_o);

endmodule

// File: rtl/rxdma_src.sv
module rxdma_src #(
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 32,
    parameter int PF_DEPTH  = 2,
    parameter int LVL_W     = $clog2(BUF_DEPTH + PF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              head_valid_o,
    output logic [LVL_W-1:0]  level_o
);

    localparam int AW    = $clog2(BUF_DEPTH);
    localparam int PFC_W = $clog2(PF_DEPTH + 1);
    localparam logic [AW:0]      BUF_FULL = (AW+1)'(BUF_DEPTH);
    localparam logic [AW-1:0]    BUF_LAST = AW'(BUF_DEPTH - 1);
    localparam logic [PFC_W-1:0] PF_FULL  = PFC_W'(PF_DEPTH);

    typedef struct packed {
        logic [AW-1:0]                  wr;
        logic [AW-1:0]                  rd;
        logic [AW:0]                    cnt;
        logic [PF_DEPTH-1:0][DATA_W-1:0] pf;
        logic [PFC_W-1:0]               pf_cnt;
    } src_t;

    src_t s_d, s_q;
    logic [DATA_W-1:0] mem [BUF_DEPTH];
    logic              wr_ok;
    logic              move;
    logic [PFC_W-1:0]  slot;

    always_comb begin
        s_d   = s_q;
        wr_ok = push_i && (s_q.cnt != BUF_FULL);
        move  = (s_q.cnt != '0) && ((s_q.pf_cnt != PF_FULL) || pop_i);
        slot  = s_q.pf_cnt;
        if (pop_i) begin
            for (int i = 0; i < PF_DEPTH - 1; i++) s_d.pf[i] = s_q.pf[i+1];
            slot     = s_q.pf_cnt - 1'b1;
            s_d.pf_cnt = slot;
        end
        if (move) begin
            s_d.pf[slot] = mem[s_q.rd];
            s_d.rd       = (s_q.rd == BUF_LAST) ? '0 : s_q.rd + 1'b1;
            s_d.pf_cnt   = slot + 1'b1;
        end
        if (wr_ok) s_d.wr = (s_q.wr == BUF_LAST) ? '0 : s_q.wr + 1'b1;
        s_d.cnt = s_q.cnt + (AW+1)'(wr_ok) - (AW+1)'(move);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[s_q.wr] <= push_data_i;
    end

    assign head_o       = s_q.pf[0];
    assign head_valid_o = (s_q.pf_cnt != '0);
    assign level_o      = LVL_W'(s_q.cnt) + LVL_W'(s_q.pf_cnt);

    // R4: a completed transfer only ever consumes a held word
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> head_valid_o);

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             eop_i,
    input  logic [1:0]       code_i,
    input  logic             ext_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             head_valid_i,
    input  logic             dmack_i,
    input  logic             rd_i,
    input  logic             eop_in_i,
    output logic             drq_o,
    output logic             rdy_o,
    output logic             pop_o,
    output logic             eop_hit_o
);

    eng_t              e_d, e_q;
    logic [BEAT_W-1:0] drop_at;

    always_comb begin
        e_d       = e_q;
        pop_o     = 1'b0;
        eop_hit_o = 1'b0;
        drop_at   = drop_index(code_i, ext_i);
        if (!en_i) begin
            e_d = '0;
        end else begin
            case (e_q.st)
                ST_IDLE: begin
                    e_d.beat = '0;
                    if (!eop_i && !dmack_i && (level_i != '0)) begin
                        e_d.st  = ST_OPEN;
                        e_d.drq = 1'b1;
                    end
                end
                default: begin
                    if (dmack_i && eop_in_i && !eop_i) begin
                        eop_hit_o = 1'b1;
                        e_d.drq   = 1'b0;
                    end
                    if (!e_q.rdy) begin
                        if (dmack_i && rd_i && head_valid_i) begin
                            e_d.rdy = 1'b1;
                            if ((e_q.beat >= drop_at) || (level_i <= LVL_W'(1)))
                                e_d.drq = 1'b0;
                        end else if (!dmack_i && !e_q.drq) begin
                            e_d.st = ST_IDLE;
                        end
                    end else if (!rd_i) begin
                        e_d.rdy = 1'b0;
                        pop_o   = 1'b1;
                        if (e_q.beat != '1) e_d.beat = e_q.beat + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign drq_o = e_q.drq;
    assign rdy_o = e_q.rdy;

    // R2: disabling the engine silences the request
    p_no_req_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !drq_o);

    // R3: ready only follows a sampled strobe under acknowledge
    p_rdy_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(rd_i && dmack_i));

    // R3: ready holds while the strobe stays high
    p_rdy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && rd_i && en_i) |=> rdy_o);

    // R4: ready always has a word behind it
    p_rdy_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> head_valid_i);

    // R7: a request rises only with data held
    p_req_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq_o) |-> $past(level_i != '0));

    // R8: no request while end-of-process is pending
    p_no_req_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_i |-> !drq_o);

endmodule

// File: rtl/rxdma_burst_ctrl.sv
module rxdma_burst_ctrl #(
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 32,
    parameter int PF_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              dmack,
    input  logic              rd_strobe,
    input  logic              eop_in,
    output logic              drq,
    output logic              rdy,
    output logic [DATA_W-1:0] rd_data,
    output logic              eop_status,
    output logic              irq
);

    localparam int LVL_W = $clog2(BUF_DEPTH + PF_DEPTH + 1);

    logic              en;
    logic [1:0]        code;
    logic              ext;
    logic              eop_hit;
    logic              pop;
    logic [DATA_W-1:0] head;
    logic              head_valid;
    logic [LVL_W-1:0]  level;

    rxdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .sel_i     (reg_sel),
        .wdata_i   (reg_wdata),
        .eop_hit_i (eop_hit),
        .en_o      (en),
        .code_o    (code),
        .ext_o     (ext),
        .eop_o     (eop_status),
        .irq_o     (irq)
    );

    rxdma_src #(
        .DATA_W    (DATA_W),
        .BUF_DEPTH (BUF_DEPTH),
        .PF_DEPTH  (PF_DEPTH),
        .LVL_W     (LVL_W)
    ) u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (fill_valid),
        .push_data_i  (fill_data),
        .pop_i        (pop),
        .head_o       (head),
        .head_valid_o (head_valid),
        .level_o      (level)
    );

    rxdma_engine #(
        .LVL_W (LVL_W)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .eop_i        (eop_status),
        .code_i       (code),
        .ext_i        (ext),
        .level_i      (level),
        .head_valid_i (head_valid),
        .dmack_i      (dmack),
        .rd_i         (rd_strobe),
        .eop_in_i     (eop_in),
        .drq_o        (drq),
        .rdy_o        (rdy),
        .pop_o        (pop),
        .eop_hit_o    (eop_hit)
    );

    assign rd_data = rdy ? head : '0;

endmodule

// File: tb/rxdma_burst_ctrl_tb.sv
module rxdma_burst_ctrl_tb_top;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              reg_we = 1'b0;
    logic              reg_sel = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic              dmack = 1'b0;
    logic              rd_strobe = 1'b0;
    logic              eop_in = 1'b0;
    logic              drq, rdy, eop_status, irq;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int consumed = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxdma_burst_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .dmack      (dmack),
        .rd_strobe  (rd_strobe),
        .eop_in     (eop_in),
        .drq        (drq),
        .rdy        (rdy),
        .rd_data    (rd_data),
        .eop_status (eop_status),
        .irq        (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input bit sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_data  = DATA_W'(16'hA000 + pushed);
            pushed++;
        end
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    function automatic int len_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 12;
        endcase
    endfunction

    task automatic wait_quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drq) seen = 1'b1;
        end
        check(!seen, req, "drq stayed low", int'(seen), 0);
    endtask

    // host reads n beats; expects drq to fall at the computed index
    task automatic host_burst(input int n, input int code, input bit ext,
                              input bit eop_last, input string req);
        int len, drop, avail, waited;
        len   = len_of(code);
        drop  = (ext && len > 1) ? len - 2 : len - 1;
        avail = pushed - consumed;
        if (avail - 1 < drop) drop = avail - 1;
        waited = 0;
        while (!drq && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check(drq == 1'b1, req, "drq before burst", int'(drq), 1);
        dmack = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_strobe = 1'b1;
            eop_in    = eop_last && (k == n - 1);
            @(negedge clk);
            check(rdy == 1'b1, "R3", "rdy after strobe", int'(rdy), 1);
            check(drq == (k < drop), req, $sformatf("drq at beat %0d", k),
                  int'(drq), int'(k < drop));
            check(rd_data == DATA_W'(16'hA000 + consumed), "R4", "read data",
                  int'(rd_data), 16'hA000 + consumed);
            consumed++;
            rd_strobe = 1'b0;
            eop_in    = 1'b0;
            @(negedge clk);
            check(rdy == 1'b0, "R3", "rdy after strobe release", int'(rdy), 0);
        end
        dmack = 1'b0;
    endtask

    task automatic t_reset;
        check(drq == 1'b0, "R2", "reset drq", int'(drq), 0);
        check(rdy == 1'b0, "R3", "reset rdy", int'(rdy), 0);
        check(eop_status == 1'b0, "R8", "reset eop", int'(eop_status), 0);
        check(irq == 1'b0, "R9", "reset irq", int'(irq), 0);
    endtask

    task automatic t_disabled;
        push_words(26);
        wait_quiet(10, "R2");
    endtask

    task automatic t_burst_lengths;
        wr_reg(1'b1, 8'h01);
        wr_reg(1'b0, 8'h02);
        host_burst(4, 1, 1'b0, 1'b0, "R1 R5 code1");
        // R6: request returns two clocks after acknowledge drops
        @(negedge clk);
        check(drq == 1'b0, "R6", "drq one clock after ack low", int'(drq), 0);
        @(negedge clk);
        check(drq == 1'b1, "R6", "drq two clocks after ack low", int'(drq), 1);
        wr_reg(1'b1, 8'h06);
        host_burst(8, 2, 1'b1, 1'b0, "R1 R5 code2 extend");
        wr_reg(1'b1, 8'h00);
        host_burst(1, 0, 1'b0, 1'b0, "R1 R5 code0");
        wr_reg(1'b1, 8'h04);
        host_burst(1, 0, 1'b1, 1'b0, "R1 R5 code0 extend");
        wr_reg(1'b1, 8'h03);
        host_burst(12, 3, 1'b0, 1'b0, "R1 R5 code3");
    endtask

    task automatic t_empty;
        wait_quiet(10, "R7");
        push_words(2);
        host_burst(2, 3, 1'b0, 1'b0, "R7 last word");
        wait_quiet(6, "R7");
    endtask

    task automatic t_eop;
        wr_reg(1'b1, 8'h01);
        push_words(4);
        host_burst(4, 1, 1'b0, 1'b1, "R8 burst");
        @(negedge clk);
        check(eop_status == 1'b1, "R8", "eop set", int'(eop_status), 1);
        check(irq == 1'b0, "R9", "irq masked", int'(irq), 0);
        wr_reg(1'b1, 8'h09);
        check(irq == 1'b1, "R9", "irq enabled", int'(irq), 1);
        push_words(3);
        wait_quiet(10, "R8");
        wr_reg(1'b0, 8'h02);
        wait_quiet(10, "R10");
        check(eop_status == 1'b1, "R10", "eop after nonzero write", int'(eop_status), 1);
        wr_reg(1'b0, 8'h00);
        check(eop_status == 1'b0, "R10", "eop after zero write", int'(eop_status), 0);
        check(irq == 1'b0, "R10", "irq after zero write", int'(irq), 0);
        wait_quiet(4, "R10");
        wr_reg(1'b0, 8'h02);
        host_burst(3, 1, 1'b0, 1'b0, "R10 R7 restart");
        wr_reg(1'b0, 8'h00);
        @(negedge clk);
        check(drq == 1'b0, "R2", "drq after disable", int'(drq), 0);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_burst_lengths;
        t_empty;
        t_eop;
        done = 1'b1;
        summary;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary;
        end
    end

endmodule